// File: doc/BRIEF.md
# Stereo PWM Output Modulator

This block turns quantized stereo sample codes, as delivered by an upstream noise-shaping stage, into differential pulse-width-modulated drive for external power stages. Each channel has two output pairs. Each pair has a positive pin and a negative pin. The high time of a pulse is the input code counted in fast-clock counts. A 2-bit form field chooses where that high time sits inside each period: at the start, centred, or alternating between the start and the end of consecutive periods. In the alternating forms the two channels either run in opposite phase or in the same phase.

A rate setting selects the code width and how fast the period counter advances. Two kinds of mute are available. Each one is driven by an active-low pin or by an active-high register bit. Duty mute replaces the audio with a 50% square wave. Zero mute stops all switching and takes precedence over duty mute. A swap control exchanges the left and right outputs. A mirror control makes the negative pin of the first pair follow its positive pin. The block samples every control and code input only at the end of a period, so a pulse never changes shape part-way through.

Top module: `stereo_pwm_mod`

## Requirements
- R1: While reset is high, and for the first 32-clock period after reset is released, all eight outputs are low. The reset configuration is zero mute at the 32x/5-bit rate.
- R2: Rate setting 0 selects 6-bit codes and a 64-count period with 2 clocks per count. Setting 1 selects 5-bit codes and a 32-count period with 2 clocks per count. Settings 2 and 3 select 5-bit codes and a 32-count period with 1 clock per count. In the 5-bit settings, code bit 5 is ignored.
- R3: With form 0, a channel's positive output is high for counts 0 to d-1 of the period, where d is its code.
- R4: With form 1, the positive output is high for counts from P/2-floor(d/2) up to P/2+ceil(d/2)-1, where P is the period in counts. An odd code therefore puts the extra count after the centre.
- R5: With form 2, periods alternate even and odd, and the first period after the reset period is even. In even periods the left channel is high for the first d counts and the right channel for the last d counts. In odd periods the two placements are exchanged.
- R6: With form 3, both channels are high for the first d counts in even periods and for the last d counts in odd periods.
- R7: Duty mute is active when duty_mute_n is low or duty_mute_reg is high. While it is active, every positive output is high for the first half of the counts and low for the second half.
- R8: Zero mute is active when zero_mute_n is low or zero_mute_reg is high. While it is active, all eight outputs stay low, even if duty mute is also active.
- R9: Outside zero mute, each negative output is the complement of its positive output, and pair 1 of each channel repeats pair 0.
- R10: With mirror_neg set, the negative output of pair 0 on each channel equals its positive output. Pair 1 keeps the complement.
- R11: With swap_lr set, the left outputs carry the right channel's pulse and the right outputs carry the left channel's pulse.
- R12: Codes and controls are sampled only at the last clock of a period. A change during a period has no effect until the next period.
- R13: An output reflects the period count one clock after the counter holds that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| code_l | input | 6 | Left channel code |
| code_r | input | 6 | Right channel code |
| form_sel | input | 2 | Pulse placement form, 0 to 3 |
| rate_sel | input | 2 | Rate and code width setting |
| duty_mute_n | input | 1 | Duty mute pin, active low |
| duty_mute_reg | input | 1 | Duty mute register bit, active high |
| zero_mute_n | input | 1 | Zero mute pin, active low |
| zero_mute_reg | input | 1 | Zero mute register bit, active high |
| swap_lr | input | 1 | Exchange left and right outputs |
| mirror_neg | input | 1 | Pair 0 negative pin follows positive pin |
| out_l_p | output | 2 | Left positive outputs, index 0 is pair 0 |
| out_l_n | output | 2 | Left negative outputs |
| out_r_p | output | 2 | Right positive outputs |
| out_r_n | output | 2 | Right negative outputs |

## Verification
The bench targets odd codes in the centred form and the extreme codes 0 and 63. A wrong half split shifts the pulse by one count, and a wrong end bound clips a full-scale pulse. It captures two consecutive periods of each alternating form, because a design that alternates on the wrong period, or gives both channels the same phase in form 2, shows a mismatch only in one of the two. It drives a code with bit 5 set at a 5-bit rate, which exposes a design that does not mask that bit and produces an over-long pulse. It changes a code half-way through a period to catch sampling outside the period boundary. It also asserts both mutes together to expose a design that lets the square wave through when zero mute should win.

// File: rtl/stereo_pwm_pkg.sv
package stereo_pwm_pkg;

  typedef enum logic [1:0] {
    FORM_EDGE     = 2'd0,
    FORM_CENTER   = 2'd1,
    FORM_ALT_OPP  = 2'd2,
    FORM_ALT_SAME = 2'd3
  } form_e;

  localparam logic [1:0] RATE_SLOW_WIDE   = 2'd0;
  localparam logic [1:0] RATE_SLOW_NARROW = 2'd1;
  localparam logic [1:0] RATE_FAST_NARROW = 2'd2;

endpackage

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slow,
  input  logic         narrow,
  output logic [W-1:0] cnt,
  output logic         phase,
  output logic         wrap
);

  logic half_q;
  logic step;
  logic [W-1:0] last;

  assign last = narrow ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
  assign step = !slow || half_q;
  assign wrap = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      half_q <= 1'b0;
      phase  <= 1'b1;
    end else begin
      half_q <= !half_q;
      if (step) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) phase <= !phase;
    end
  end

  // R2: a narrow period never reaches the upper half of the counter range
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    narrow |-> (cnt[W-1] == 1'b0));

  // R2: at the slow rates the count is held for two clocks
  assert_slow_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (slow && !half_q) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/spwm_shaper.sv
module spwm_shaper
  import stereo_pwm_pkg::*;
#(
  parameter int W       = 6,
  parameter bit IS_LEFT = 1'b1
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] code,
  input  logic         narrow,
  input  form_e        form,
  input  logic         phase,
  output logic         pulse
);

  localparam int PW = W + 1;

  logic [PW-1:0] span, mid, d, c, lo, hi;
  logic lead, trail, centre;

  always_comb begin
    span   = narrow ? (PW'(1) << (W - 1)) : (PW'(1) << W);
    mid    = span >> 1;
    d      = narrow ? {2'b00, code[W-2:0]} : {1'b0, code};
    c      = {1'b0, cnt};
    lo     = mid - (d >> 1);
    hi     = mid + (d - (d >> 1));
    lead   = c < d;
    trail  = c >= (span - d);
    centre = (c >= lo) && (c < hi);
    case (form)
      FORM_EDGE:    pulse = lead;
      FORM_CENTER:  pulse = centre;
      FORM_ALT_OPP: pulse = IS_LEFT ? (phase ? trail : lead) : (phase ? lead : trail);
      default:      pulse = phase ? trail : lead;
    endcase
  end

endmodule

// File: rtl/spwm_outstage.sv
module spwm_outstage #(
  parameter int W     = 6,
  parameter int PAIRS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_l,
  input  logic             pulse_r,
  input  logic [W-1:0]     cnt,
  input  logic             narrow,
  input  logic             duty,
  input  logic             zero,
  input  logic             swap,
  input  logic             mirror,
  output logic [PAIRS-1:0] out_l_p,
  output logic [PAIRS-1:0] out_l_n,
  output logic [PAIRS-1:0] out_r_p,
  output logic [PAIRS-1:0] out_r_n
);

  logic [W-1:0] half_cnt;
  logic sq, a_l, a_r;

  assign half_cnt = narrow ? (W'(1) << (W - 2)) : (W'(1) << (W - 1));
  assign sq  = cnt < half_cnt;
  assign a_l = duty ? sq : (swap ? pulse_r : pulse_l);
  assign a_r = duty ? sq : (swap ? pulse_l : pulse_r);

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    localparam bit MIRROR_OK = (g == 0);
    always_ff @(posedge clk) begin
      if (rst || zero) begin
        out_l_p[g] <= 1'b0;
        out_l_n[g] <= 1'b0;
        out_r_p[g] <= 1'b0;
        out_r_n[g] <= 1'b0;
      end else begin
        out_l_p[g] <= a_l;
        out_r_p[g] <= a_r;
        out_l_n[g] <= (MIRROR_OK && mirror) ? a_l : !a_l;
        out_r_n[g] <= (MIRROR_OK && mirror) ? a_r : !a_r;
      end
    end
  end

  // R8: zero mute silences every pin on the following clock
  assert_zero_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    zero |=> ((out_l_p | out_l_n | out_r_p | out_r_n) == '0));

  // R7: under duty mute both channels switch together
  assert_duty_match_R7: assert property (@(posedge clk) disable iff (rst)
    (duty && !zero) |=> (out_l_p == out_r_p));

  // R9: every pair repeats pair 0 on its positive pin
  assert_pair_copy_R9: assert property (@(posedge clk) disable iff (rst)
    !zero |=> ((out_l_p == {PAIRS{out_l_p[0]}}) && (out_r_p == {PAIRS{out_r_p[0]}})));

endmodule

// File: rtl/stereo_pwm_mod.sv
module stereo_pwm_mod
  import stereo_pwm_pkg::*;
#(
  parameter int W     = 6,
  parameter int PAIRS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     code_l,
  input  logic [W-1:0]     code_r,
  input  logic [1:0]       form_sel,
  input  logic [1:0]       rate_sel,
  input  logic             duty_mute_n,
  input  logic             duty_mute_reg,
  input  logic             zero_mute_n,
  input  logic             zero_mute_reg,
  input  logic             swap_lr,
  input  logic             mirror_neg,
  output logic [PAIRS-1:0] out_l_p,
  output logic [PAIRS-1:0] out_l_n,
  output logic [PAIRS-1:0] out_r_p,
  output logic [PAIRS-1:0] out_r_n
);

  localparam int CH = 2;

  logic [CH-1:0][W-1:0] code_q;
  form_e  form_q;
  logic   slow_q, narrow_q, duty_q, zero_q, swap_q, mirror_q;
  logic [W-1:0] cnt;
  logic   phase, wrap;
  logic [CH-1:0] pulse;

  spwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst(rst), .slow(slow_q), .narrow(narrow_q),
    .cnt(cnt), .phase(phase), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      form_q   <= FORM_EDGE;
      slow_q   <= 1'b0;
      narrow_q <= 1'b1;
      duty_q   <= 1'b0;
      zero_q   <= 1'b1;
      swap_q   <= 1'b0;
      mirror_q <= 1'b0;
    end else if (wrap) begin
      code_q   <= {code_r, code_l};
      form_q   <= form_e'(form_sel);
      slow_q   <= !rate_sel[1];
      narrow_q <= (rate_sel != RATE_SLOW_WIDE);
      duty_q   <= !duty_mute_n || duty_mute_reg;
      zero_q   <= !zero_mute_n || zero_mute_reg;
      swap_q   <= swap_lr;
      mirror_q <= mirror_neg;
    end
  end

  for (genvar ch = 0; ch < CH; ch++) begin : g_chan
    spwm_shaper #(.W(W), .IS_LEFT(ch == 0)) u_shp (
      .cnt(cnt), .code(code_q[ch]), .narrow(narrow_q),
      .form(form_q), .phase(phase), .pulse(pulse[ch])
    );
  end

  spwm_outstage #(.W(W), .PAIRS(PAIRS)) u_out (
    .clk(clk), .rst(rst), .pulse_l(pulse[0]), .pulse_r(pulse[1]),
    .cnt(cnt), .narrow(narrow_q), .duty(duty_q), .zero(zero_q),
    .swap(swap_q), .mirror(mirror_q),
    .out_l_p(out_l_p), .out_l_n(out_l_n), .out_r_p(out_r_p), .out_r_n(out_r_n)
  );

  // R12: the sampled configuration holds between period boundaries
  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(code_q) && $stable(form_q) && $stable(zero_q) && $stable(duty_q)));

  // R12: a new period always starts from count zero
  assert_wrap_zero_R12: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

endmodule

// File: tb/stereo_pwm_mod_tb.sv
module stereo_pwm_mod_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] code_l = '0, code_r = '0;
  logic [1:0] form_sel = '0, rate_sel = 2'd2;
  logic duty_mute_n = 1'b1, duty_mute_reg = 1'b0;
  logic zero_mute_n = 1'b1, zero_mute_reg = 1'b0;
  logic swap_lr = 1'b0, mirror_neg = 1'b0;
  logic [1:0] out_l_p, out_l_n, out_r_p, out_r_n;

  int checks = 0;
  int errors = 0;
  int ncyc   = 0;
  int ns     = 0;
  bit nphase = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;

  stereo_pwm_mod u_dut (
    .clk(clk), .rst(rst), .code_l(code_l), .code_r(code_r),
    .form_sel(form_sel), .rate_sel(rate_sel),
    .duty_mute_n(duty_mute_n), .duty_mute_reg(duty_mute_reg),
    .zero_mute_n(zero_mute_n), .zero_mute_reg(zero_mute_reg),
    .swap_lr(swap_lr), .mirror_neg(mirror_neg),
    .out_l_p(out_l_p), .out_l_n(out_l_n), .out_r_p(out_r_p), .out_r_n(out_r_n)
  );

  function automatic logic [7:0] packed_out();
    return {out_l_p[1], out_l_n[1], out_l_p[0], out_l_n[0],
            out_r_p[1], out_r_n[1], out_r_p[0], out_r_n[0]};
  endfunction

  function automatic int len_of(logic [1:0] rs);
    if (rs == 2'd0) return 128;
    if (rs == 2'd1) return 64;
    return 32;
  endfunction

  function automatic bit shape(int d, int p, int c, logic [1:0] f, bit ph, bit left);
    bit lead  = c < d;
    bit trail = c >= p - d;
    int lo    = p / 2 - d / 2;
    int hi    = p / 2 + (d - d / 2);
    case (f)
      2'd0: return lead;
      2'd1: return (c >= lo) && (c < hi);
      2'd2: return left ? (ph ? trail : lead) : (ph ? lead : trail);
      default: return ph ? trail : lead;
    endcase
  endfunction

  function automatic logic [7:0] model(logic [5:0] cl, cr, logic [1:0] f, rs,
                                       bit dmn, dmr, zmn, zmr, sw, mir, int c, bit ph);
    int p  = (rs == 2'd0) ? 64 : 32;
    int dl = (rs == 2'd0) ? int'(cl) : int'(cl[4:0]);
    int dr = (rs == 2'd0) ? int'(cr) : int'(cr[4:0]);
    bit pl = shape(dl, p, c, f, ph, 1'b1);
    bit pr = shape(dr, p, c, f, ph, 1'b0);
    bit a, b;
    if (!zmn || zmr) return 8'h00;
    if (!dmn || dmr) begin pl = c < p / 2; pr = pl; end
    a = sw ? pr : pl;
    b = sw ? pl : pr;
    return {a, !a, a, mir ? a : !a, b, !b, b, mir ? b : !b};
  endfunction

  task automatic tick();
    @(negedge clk);
    ncyc++;
  endtask

  task automatic report(bit ok, string req, logic [7:0] act, logic [7:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp_v);
    end
  endtask

  // R1: reset state and the zero-muted first period
  task automatic t_reset();
    bit ok = 1'b1;
    logic [7:0] bad = '0;
    code_l = 6'd10; code_r = 6'd20; rate_sel = 2'd2; form_sel = 2'd0;
    if (packed_out() != 8'h00) begin ok = 1'b0; bad = packed_out(); end
    for (int i = 0; i < 32; i++) begin
      tick();
      if (ok && packed_out() != 8'h00) begin ok = 1'b0; bad = packed_out(); end
    end
    report(ok, "R1 reset outputs low", bad, 8'h00);
    ns = 33 + 32;
    nphase = 1'b1;
  endtask

  task automatic run_case(string req, logic [5:0] cl, cr, logic [1:0] f, rs,
                          bit dmn, dmr, zmn, zmr, sw, mir, bit midchg, logic [5:0] cl2);
    int L = len_of(rs);
    code_l = cl; code_r = cr; form_sel = f; rate_sel = rs;
    duty_mute_n = dmn; duty_mute_reg = dmr; zero_mute_n = zmn; zero_mute_reg = zmr;
    swap_lr = sw; mirror_neg = mir;
    while (ncyc < ns - 1) tick();
    for (int pi = 0; pi < 2; pi++) begin
      bit ph = nphase ^ pi[0];
      logic [5:0] clp = (pi == 1 && midchg) ? cl2 : cl;
      bit ok = 1'b1;
      logic [7:0] ba = '0, be = '0;
      for (int j = 0; j < L; j++) begin
        int c = rs[1] ? j : j / 2;
        logic [7:0] e;
        tick();
        e = model(clp, cr, f, rs, dmn, dmr, zmn, zmr, sw, mir, c, ph);
        if (ok && packed_out() !== e) begin ok = 1'b0; ba = packed_out(); be = e; end
        if (midchg && pi == 0 && j == L / 2) code_l = cl2;
      end
      report(ok, $sformatf("%s period %0d", req, pi), ba, be);
    end
    ns = ns + 3 * L;
    nphase = !nphase;
  endtask

  task automatic t_edge_form();
    run_case("R3 R9 R13 edge form fast rate", 6'd10, 6'd25, 2'd0, 2'd2, 1,0,1,0, 0,0, 0, 6'd0);
  endtask
  task automatic t_rates();
    run_case("R2 wide 6-bit rate", 6'd50, 6'd63, 2'd0, 2'd0, 1,0,1,0, 0,0, 0, 6'd0);
    run_case("R2 narrow slow rate masks bit 5", 6'h2A, 6'd5, 2'd0, 2'd1, 1,0,1,0, 0,0, 0, 6'd0);
  endtask
  task automatic t_center();
    run_case("R4 centred odd code", 6'd7, 6'd31, 2'd1, 2'd2, 1,0,1,0, 0,0, 0, 6'd0);
    run_case("R4 centred extremes wide", 6'd0, 6'd63, 2'd1, 2'd0, 1,0,1,0, 0,0, 0, 6'd0);
  endtask
  task automatic t_alt();
    run_case("R5 alternating opposite", 6'd9, 6'd20, 2'd2, 2'd2, 1,0,1,0, 0,0, 0, 6'd0);
    run_case("R6 alternating same", 6'd12, 6'd3, 2'd3, 2'd1, 1,0,1,0, 0,0, 0, 6'd0);
  endtask
  task automatic t_duty();
    run_case("R7 duty mute by pin", 6'd5, 6'd40, 2'd0, 2'd2, 0,0,1,0, 0,0, 0, 6'd0);
    run_case("R7 duty mute by register", 6'd5, 6'd40, 2'd1, 2'd0, 1,1,1,0, 0,0, 0, 6'd0);
  endtask
  task automatic t_zero();
    run_case("R8 zero mute pin over duty", 6'd17, 6'd9, 2'd0, 2'd2, 0,0,0,0, 0,1, 0, 6'd0);
    run_case("R8 zero mute by register", 6'd17, 6'd9, 2'd3, 2'd1, 1,0,1,1, 1,0, 0, 6'd0);
  endtask
  task automatic t_mirror();
    run_case("R10 mirror pair 0", 6'd14, 6'd22, 2'd0, 2'd2, 1,0,1,0, 0,1, 0, 6'd0);
  endtask
  task automatic t_swap();
    run_case("R11 swap channels", 6'd4, 6'd28, 2'd2, 2'd3, 1,0,1,0, 1,0, 0, 6'd0);
  endtask
  task automatic t_midchange();
    run_case("R12 mid-period code change", 6'd4, 6'd11, 2'd0, 2'd2, 1,0,1,0, 0,0, 1, 6'd20);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    ncyc = 0;
    t_reset();
    t_edge_form();
    t_rates();
    t_center();
    t_alt();
    t_duty();
    t_zero();
    t_mirror();
    t_swap();
    t_midchange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule